// File: doc/BRIEF.md
# 1-Wire ROM Command State Machine

This block runs the addressing phase of a 1-Wire slave. It sits between the bit-level layer and the device-function layer. The bit-level layer tells it when a reset/presence cycle has finished and whether the reset pulse was long. It also reports each finished time slot with the bit seen on the line. From that stream the block picks up an 8-bit ROM command, least significant bit first. It then runs that command against a 64-bit identifier that arrives whole on an input port. When addressing succeeds it raises a level that hands the bus over to the device-function layer until the next reset. When addressing fails it stays silent until the next reset.

For read-type slots the block raises `tx_active` and places the bit to send on `tx_bit`. The bit layer pulls the line low during a read slot only when `tx_active` is 1 and `tx_bit` is 0. Two flags are kept across bus resets. The resume flag marks the device as the last one addressed. The overdrive flag selects fast timing in the bit layer and is cleared only by a long reset.

Identifier layout on `rom_id` (bit 0 goes on the wire first):
- bits 7:0 hold the family code;
- bits 55:8 hold the 48-bit serial number;
- bits 63:56 hold the check byte.

States:
- `ST_CMD`: receive the command byte.
- `ST_READ`: send the identifier.
- `ST_MATCH`: compare incoming bits.
- `ST_SRCH_T`, `ST_SRCH_C`, `ST_SRCH_M`: the three slots of one search step (true bit, complement bit, master's choice).
- `ST_FUNC`: control passed to the device-function layer.
- `ST_WAIT`: silent until reset.

Transitions:
- A bus reset goes from any state to `ST_CMD`.
- The eighth command bit leads from `ST_CMD` to one of the following:
  - `ST_READ` for 33h;
  - `ST_MATCH` for 55h and 69h;
  - `ST_SRCH_T` for F0h;
  - `ST_FUNC` for CCh, for 3Ch, and for A5h when the resume flag is 1;
  - `ST_WAIT` for A5h when the resume flag is 0, and for any other byte.
- `ST_READ` goes to `ST_FUNC` after bit 63.
- `ST_MATCH` and `ST_SRCH_M` go to `ST_WAIT` on a mismatching bit, and to `ST_FUNC` after a matching bit 63.
- `ST_SRCH_T` goes to `ST_SRCH_C`, which goes to `ST_SRCH_M`.
- `ST_SRCH_M` goes back to `ST_SRCH_T` after a matching bit that is not the last.

Top module: `owr_rom_fsm`

## Requirements
- R1: After `rst_n` is released, `dev_sel`, `tx_active`, `rc_flag` and `od_mode` are all 0, and the block waits for a command byte.
- R2: The command byte is assembled least significant bit first from eight write slots. A bus reset part-way through a byte discards the bits received so far, and `dev_sel` and `tx_active` are 0 in the cycle after any bus reset.
- R3: Command 33h clears `rc_flag`. It then sends `rom_id` over 64 read slots, bit 0 first: family code, then serial number, then check byte. After the last slot `dev_sel` is 1.
- R4: Command 55h clears `rc_flag` and compares 64 write slots with `rom_id`, bit 0 first. If every bit matches, `rc_flag` and `dev_sel` become 1. A mismatch at any bit leaves both at 0 until the next reset.
- R5: Command F0h clears `rc_flag`. For each bit, starting at bit 0, it sends the true bit in one read slot and the complement in the next. It then takes the master's bit from a write slot. On a mismatch it drops out: `tx_active` stays 0 and `dev_sel` stays 0 until reset. After a complete pass `rc_flag` and `dev_sel` are 1.
- R6: Command CCh clears `rc_flag` and sets `dev_sel`.
- R7: Command A5h sets `dev_sel` when `rc_flag` is 1 and leaves `rc_flag` unchanged. With `rc_flag` at 0 it keeps `dev_sel` at 0 until reset.
- R8: Command 3Ch sets `od_mode`, clears `rc_flag` and sets `dev_sel`.
- R9: Command 69h sets `od_mode` as soon as the command byte is complete, whatever the outcome of the compare. It then behaves as R4.
- R10: A bus reset with `reset_long` set clears `od_mode`. A bus reset without it leaves `od_mode` unchanged. Every bus reset leaves `rc_flag` unchanged.
- R11: Any command byte other than the seven listed leaves `dev_sel` at 0 and both flags unchanged until the next reset.
- R12: In the function and silent states, slots have no effect on the flags or on `dev_sel`, and `tx_active` is 0. `tx_active` and `dev_sel` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a reset/presence cycle has finished |
| reset_long | input | 1 | Qualifies `bus_reset`: the reset low time was at least 480 us |
| slot_done | input | 1 | One-cycle pulse: a time slot has finished |
| slot_bit | input | 1 | Line value sampled in the finished slot |
| rom_id | input | ID_W | Device identifier, bit 0 sent first |
| tx_active | output | 1 | The current slot is a read slot driven by this block |
| tx_bit | output | 1 | Bit to send in the current read slot |
| dev_sel | output | 1 | Control handed to the device-function layer |
| rc_flag | output | 1 | Resume flag |
| od_mode | output | 1 | Overdrive timing selected |

## Verification
A wrong state register shows up at the ports within one slot. A read state entered by mistake raises `tx_active`. A missed command leaves `dev_sel` low after the eighth bit. A search that drops out at the wrong bit shows `tx_active` low in the very next read slot. Bad flag handling is visible one cycle after the deciding slot or reset, because `rc_flag` and `od_mode` are registered outputs. Errors in the identifier bit index appear as a wrong `tx_bit` in read or search slots. In compare commands they appear as a wrong `dev_sel` at the end of the pass.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_T,
        ST_SRCH_C,
        ST_SRCH_M,
        ST_FUNC,
        ST_WAIT
    } rom_state_t;

    localparam int unsigned CMD_BITS = 8;

    localparam logic [CMD_BITS-1:0] OP_READ      = 8'h33;
    localparam logic [CMD_BITS-1:0] OP_MATCH     = 8'h55;
    localparam logic [CMD_BITS-1:0] OP_SEARCH    = 8'hF0;
    localparam logic [CMD_BITS-1:0] OP_SKIP      = 8'hCC;
    localparam logic [CMD_BITS-1:0] OP_RESUME    = 8'hA5;
    localparam logic [CMD_BITS-1:0] OP_FAST_SKIP = 8'h3C;
    localparam logic [CMD_BITS-1:0] OP_FAST_MTCH = 8'h69;

endpackage

// File: rtl/owr_bit_ctr.sv
// Index counter over COUNT positions with clear priority and a last flag.
module owr_bit_ctr #(
    parameter int unsigned COUNT = 64,
    localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    assign at_last = (cnt == CW'(COUNT - 1));
endmodule

// File: rtl/owr_cmd_rx.sv
// Assembles a command word least significant bit first.
module owr_cmd_rx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         take,
    input  logic         din,
    output logic         byte_done,
    output logic [W-1:0] cmd_byte
);
    logic [W-1:0] sr_q;
    logic         last_bit;
    logic [((W > 1) ? $clog2(W) : 1)-1:0] pos;

    owr_bit_ctr #(.COUNT(W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .inc     (take),
        .cnt     (pos),
        .at_last (last_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (restart) begin
            sr_q <= '0;
        end else if (take) begin
            sr_q <= {din, sr_q[W-1:1]};
        end
    end

    assign byte_done = take && last_bit;
    assign cmd_byte  = {din, sr_q[W-1:1]};
endmodule

// File: rtl/owr_rom_flags.sv
// Resume and overdrive flags; a clear of overdrive wins over a set.
module owr_rom_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_set,
    input  logic rc_clr,
    input  logic od_set,
    input  logic od_clr,
    output logic rc_q,
    output logic od_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_q <= 1'b0;
        end else if (rc_clr) begin
            rc_q <= 1'b0;
        end else if (rc_set) begin
            rc_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            od_q <= 1'b0;
        end else if (od_clr) begin
            od_q <= 1'b0;
        end else if (od_set) begin
            od_q <= 1'b1;
        end
    end
endmodule

// File: rtl/owr_rom_fsm.sv
module owr_rom_fsm
    import owr_rom_pkg::*;
#(
    parameter int unsigned ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            reset_long,
    input  logic            slot_done,
    input  logic            slot_bit,
    input  logic [ID_W-1:0] rom_id,
    output logic            tx_active,
    output logic            tx_bit,
    output logic            dev_sel,
    output logic            rc_flag,
    output logic            od_mode
);
    localparam int unsigned IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

    rom_state_t st_q, st_d;

    logic [IDX_W-1:0]    idx;
    logic                idx_last, idx_inc, idx_clr;
    logic                byte_done;
    logic [CMD_BITS-1:0] cmd_byte;
    logic                cmd_take;
    logic                rc_set, rc_clr, od_set;
    logic                id_bit;

    assign cmd_take = slot_done && !bus_reset && (st_q == ST_CMD);
    assign id_bit   = rom_id[idx];

    owr_cmd_rx #(.W(CMD_BITS)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (bus_reset),
        .take      (cmd_take),
        .din       (slot_bit),
        .byte_done (byte_done),
        .cmd_byte  (cmd_byte)
    );

    owr_bit_ctr #(.COUNT(ID_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (idx_clr),
        .inc     (idx_inc),
        .cnt     (idx),
        .at_last (idx_last)
    );

    owr_rom_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rc_set (rc_set),
        .rc_clr (rc_clr),
        .od_set (od_set),
        .od_clr (bus_reset && reset_long),
        .rc_q   (rc_flag),
        .od_q   (od_mode)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_CMD;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and flag controls
    always_comb begin
        st_d    = st_q;
        rc_set  = 1'b0;
        rc_clr  = 1'b0;
        od_set  = 1'b0;
        idx_inc = 1'b0;
        idx_clr = 1'b0;
        if (bus_reset) begin
            st_d    = ST_CMD;
            idx_clr = 1'b1;
        end else if (slot_done) begin
            unique case (st_q)
                ST_CMD: begin
                    if (byte_done) begin
                        idx_clr = 1'b1;
                        case (cmd_byte)
                            OP_READ: begin
                                rc_clr = 1'b1;
                                st_d   = ST_READ;
                            end
                            OP_MATCH: begin
                                rc_clr = 1'b1;
                                st_d   = ST_MATCH;
                            end
                            OP_FAST_MTCH: begin
                                rc_clr = 1'b1;
                                od_set = 1'b1;
                                st_d   = ST_MATCH;
                            end
                            OP_SEARCH: begin
                                rc_clr = 1'b1;
                                st_d   = ST_SRCH_T;
                            end
                            OP_SKIP: begin
                                rc_clr = 1'b1;
                                st_d   = ST_FUNC;
                            end
                            OP_FAST_SKIP: begin
                                rc_clr = 1'b1;
                                od_set = 1'b1;
                                st_d   = ST_FUNC;
                            end
                            OP_RESUME: begin
                                st_d = rc_flag ? ST_FUNC : ST_WAIT;
                            end
                            default: begin
                                st_d = ST_WAIT;
                            end
                        endcase
                    end
                end
                ST_READ: begin
                    if (idx_last) begin
                        st_d = ST_FUNC;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (slot_bit != id_bit) begin
                        st_d = ST_WAIT;
                    end else if (idx_last) begin
                        rc_set = 1'b1;
                        st_d   = ST_FUNC;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
                ST_SRCH_T: st_d = ST_SRCH_C;
                ST_SRCH_C: st_d = ST_SRCH_M;
                ST_SRCH_M: begin
                    if (slot_bit != id_bit) begin
                        st_d = ST_WAIT;
                    end else if (idx_last) begin
                        rc_set = 1'b1;
                        st_d   = ST_FUNC;
                    end else begin
                        idx_inc = 1'b1;
                        st_d    = ST_SRCH_T;
                    end
                end
                ST_FUNC: st_d = ST_FUNC;
                ST_WAIT: st_d = ST_WAIT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_active = 1'b0;
        tx_bit    = 1'b1;
        dev_sel   = 1'b0;
        unique case (st_q)
            ST_READ, ST_SRCH_T: begin
                tx_active = 1'b1;
                tx_bit    = id_bit;
            end
            ST_SRCH_C: begin
                tx_active = 1'b1;
                tx_bit    = ~id_bit;
            end
            ST_FUNC: dev_sel = 1'b1;
            ST_CMD, ST_MATCH, ST_SRCH_M, ST_WAIT: begin
                tx_active = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/owr_rom_chk.sv
module owr_rom_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic reset_long,
    input logic slot_done,
    input logic tx_active,
    input logic dev_sel,
    input logic rc_flag,
    input logic od_mode
);
    // R2
    reset_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!dev_sel && !tx_active));

    // R10
    long_reset_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && reset_long) |=> !od_mode);

    // R10
    short_reset_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !reset_long) |=> $stable(od_mode));

    // R10
    reset_keeps_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> $stable(rc_flag));

    // R12
    rc_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_done && !bus_reset) |=> $stable(rc_flag));

    // R8
    od_rise_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_mode) |-> $past(slot_done));

    // R12
    sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel && !bus_reset) |=> dev_sel);

    // R12
    sel_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_sel && tx_active));
endmodule

bind owr_rom_fsm owr_rom_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .reset_long (reset_long),
    .slot_done  (slot_done),
    .tx_active  (tx_active),
    .dev_sel    (dev_sel),
    .rc_flag    (rc_flag),
    .od_mode    (od_mode)
);

// File: tb/tb_owr_rom_fsm.sv
module tb_owr_rom_fsm;
    localparam int ID_W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_reset = 1'b0;
    logic            reset_long = 1'b0;
    logic            slot_done = 1'b0;
    logic            slot_bit = 1'b1;
    logic [ID_W-1:0] rom_id = '0;
    logic            tx_active, tx_bit, dev_sel, rc_flag, od_mode;

    int tests = 0;
    int fails = 0;
    bit exp_rc = 1'b0;
    bit exp_od = 1'b0;

    always #10 clk = ~clk;

    owr_rom_fsm #(.ID_W(ID_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .reset_long (reset_long),
        .slot_done  (slot_done),
        .slot_bit   (slot_bit),
        .rom_id     (rom_id),
        .tx_active  (tx_active),
        .tx_bit     (tx_bit),
        .dev_sel    (dev_sel),
        .rc_flag    (rc_flag),
        .od_mode    (od_mode)
    );

    function automatic bit known_op(input logic [7:0] op);
        return op inside {8'h33, 8'h55, 8'hF0, 8'hCC, 8'hA5, 8'h3C, 8'h69};
    endfunction

    function automatic string op_tag(input logic [7:0] op);
        case (op)
            8'h33:   return "R3";
            8'h55:   return "R4";
            8'hF0:   return "R5";
            8'hCC:   return "R6";
            8'hA5:   return "R7";
            8'h3C:   return "R8";
            8'h69:   return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_rst(input bit lng);
        @(negedge clk);
        bus_reset  = 1'b1;
        reset_long = lng;
        @(negedge clk);
        bus_reset  = 1'b0;
        reset_long = 1'b0;
        if (lng) exp_od = 1'b0;
    endtask

    task automatic wr(input bit b);
        @(negedge clk);
        slot_bit  = b;
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        slot_bit  = 1'b1;
    endtask

    task automatic rd(output bit act, output bit val);
        @(negedge clk);
        act       = tx_active;
        val       = tx_bit;
        slot_bit  = act ? val : 1'b1;
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        slot_bit  = 1'b1;
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int i = 0; i < 8; i++) wr(op[i]);
    endtask

    task automatic flags_chk(input string tag, input bit exp_sel);
        chk(dev_sel == exp_sel, tag, dev_sel, exp_sel);
        chk(rc_flag == exp_rc, tag, rc_flag, exp_rc);
        chk(od_mode == exp_od, tag, od_mode, exp_od);
    endtask

    // flip: position of a wrong master bit (>= ID_W means none)
    task automatic run_op(input logic [7:0] op, input int flip, input bit lng);
        bit    a, v, c_a, c_v, alive, sel;
        string tag;
        tag = op_tag(op);
        bus_rst(lng);
        chk(!dev_sel && !tx_active, "R2", {dev_sel, tx_active}, 0);
        send_op(op);
        sel = 1'b0;
        case (op)
            8'h33: begin
                exp_rc = 1'b0;
                for (int i = 0; i < ID_W; i++) begin
                    rd(a, v);
                    chk(a && (v == rom_id[i]), "R3", {a, v}, {1'b1, rom_id[i]});
                end
                sel = 1'b1;
            end
            8'h55, 8'h69: begin
                if (op == 8'h69) begin
                    exp_od = 1'b1;
                    @(negedge clk);
                    chk(od_mode == 1'b1, "R9", od_mode, 1);
                end
                exp_rc = 1'b0;
                alive  = 1'b1;
                for (int i = 0; i < ID_W; i++) begin
                    wr(rom_id[i] ^ (i == flip));
                    if (i == flip) alive = 1'b0;
                end
                sel    = alive;
                exp_rc = alive;
            end
            8'hF0: begin
                exp_rc = 1'b0;
                alive  = 1'b1;
                for (int i = 0; i < ID_W; i++) begin
                    rd(a, v);
                    rd(c_a, c_v);
                    if (alive) begin
                        chk(a && v == rom_id[i], "R5", {a, v}, {1'b1, rom_id[i]});
                        chk(c_a && c_v == !rom_id[i], "R5", {c_a, c_v}, {1'b1, !rom_id[i]});
                    end else begin
                        chk(!a && !c_a, "R5", {a, c_a}, 0);
                    end
                    wr(rom_id[i] ^ (i == flip));
                    if (i == flip) alive = 1'b0;
                end
                sel    = alive;
                exp_rc = alive;
            end
            8'hCC: begin
                exp_rc = 1'b0;
                sel    = 1'b1;
            end
            8'hA5: sel = exp_rc;
            8'h3C: begin
                exp_rc = 1'b0;
                exp_od = 1'b1;
                sel    = 1'b1;
            end
            default: sel = 1'b0;
        endcase
        @(negedge clk);
        flags_chk(tag, sel);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R1-R12 run: act=hung exp=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit a, v;
        logic [7:0] op;
        void'($urandom(32'h51C0_0DE5));
        rom_id = {$urandom(), $urandom()};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!dev_sel && !tx_active && !rc_flag && !od_mode, "R1",
            {dev_sel, tx_active, rc_flag, od_mode}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dev_sel && !tx_active && !rc_flag && !od_mode, "R1",
            {dev_sel, tx_active, rc_flag, od_mode}, 0);

        // R2: partial command, then reset, then skip
        for (int i = 0; i < 4; i++) wr(1'b1);
        run_op(8'hCC, ID_W, 1'b0);

        run_op(8'h33, ID_W, 1'b1);     // R3
        run_op(8'h55, ID_W, 1'b0);     // R4 full match
        run_op(8'hA5, ID_W, 1'b0);     // R7 resume after match
        run_op(8'h55, ID_W - 1, 1'b0); // R4 mismatch on last bit
        run_op(8'hA5, ID_W, 1'b0);     // R7 resume with rc 0
        // R12: silent state ignores slots
        rd(a, v);
        chk(!a && !dev_sel, "R12", {a, dev_sel}, 0);
        run_op(8'hF0, ID_W, 1'b0);     // R5 full pass
        run_op(8'hF0, 0, 1'b0);        // R5 drop at bit 0
        run_op(8'h55, ID_W, 1'b0);
        run_op(8'h00, ID_W, 1'b0);     // R11 unknown keeps rc
        run_op(8'h3C, ID_W, 1'b0);     // R8
        // R12: function state ignores slots
        for (int i = 0; i < 8; i++) wr(1'b0);
        rd(a, v);
        chk(!a && dev_sel, "R12", {a, dev_sel}, 2'b01);
        flags_chk("R12", 1'b1);
        run_op(8'hCC, ID_W, 1'b0);     // R10 short reset keeps od
        run_op(8'hCC, ID_W, 1'b1);     // R10 long reset clears od
        run_op(8'h69, ID_W, 1'b0);     // R9 full match
        run_op(8'h69, 17, 1'b1);       // R9 mismatch, od still set

        for (int n = 0; n < 40; n++) begin
            case ($urandom_range(7))
                0: op = 8'h33;
                1: op = 8'h55;
                2: op = 8'hF0;
                3: op = 8'hCC;
                4: op = 8'hA5;
                5: op = 8'h3C;
                6: op = 8'h69;
                default: begin
                    op = 8'($urandom());
                    if (known_op(op)) op = 8'h00;
                end
            endcase
            if ($urandom_range(3) == 0) rom_id = {$urandom(), $urandom()};
            run_op(op, int'($urandom_range(ID_W + 40)), 1'($urandom_range(1)));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule